// File: doc/BRIEF.md
# Three-Wire Synthesiser Programming Interface

This block is the serial control port of a frequency synthesiser. A host drives three lines: a data line, a serial clock and an enable line. While enable is high, each rising edge of the serial clock shifts one data bit into a 28-bit word, most significant bit first. When enable falls, the word is committed. The reference-divider select, charge-pump current, test-mode flag and four port latches update at once. The 17-bit divider ratio is first placed in a pending register. It only reaches the programmable divider when that divider reports the end of its count cycle, so a retune never cuts a divider cycle short.

The three serial lines are asynchronous to the system clock. Each one passes through a two-stage synchroniser, and edges are found on the synchronised levels. Every serial level must therefore last several system clocks. The four port outputs model open-drain drivers. A 1 pulls the pin low and a 0 leaves it at high impedance. All ports come out of reset at high impedance and stay there until the first word is committed.

Top module: `synth_prog_if`

## Requirements
- R1: The word is 28 bits, sent MSB first. Bits [16:0] are the divider ratio, bits [20:17] the reference-divider select, bits [22:21] the charge-pump current code, bit [23] the test-mode flag and bits [27:24] the port latches (bit 24 drives port 0).
- R2: The serial clock shifts a bit only while enable is high. Serial clock edges while enable is low leave the shifted word untouched.
- R3: On a falling edge of enable, the reference select, charge-pump code, test flag and port latches take the upper 11 bits of the shifted word. They appear at the outputs three system clocks after the enable pin falls, and they change at no other time.
- R4: A commit stores the ratio bits as pending. The ratio output changes only on the clock after a `div_cycle_end` pulse, and only when a value is pending. Otherwise it keeps its value.
- R5: After reset every output is zero, so all ports are at high impedance. The ports stay at high impedance until the first commit.
- R6: A transfer with other than 28 bits commits the last 28 bits shifted in. With fewer bits, the earlier contents move up by the number of new bits.
- R7: Raising and lowering enable with no serial clock edge in between commits the unchanged word.
- R8: When several commits occur before a divider cycle end, the ratio applied is the one from the latest commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Transfer enable, asynchronous; falling edge commits |
| div_cycle_end | input | 1 | One-clock pulse at the end of a divider count cycle |
| ratio_o | output | 17 | Divider ratio applied to the programmable divider |
| ref_sel_o | output | 4 | Reference-divider select code |
| cp_cur_o | output | 2 | Charge-pump current code |
| test_mode_o | output | 1 | Test-mode flag |
| port_sink_o | output | 4 | Port drivers: 1 pulls the pin low, 0 leaves it at high impedance |

## Verification
The assertions assume three things about the serial inputs. Every serial level lasts at least three system clocks. Data is stable across each serial clock rising edge. Enable changes only while the serial clock is low. The bench meets these by holding each data, clock and enable phase for three or four system clocks. It toggles enable only after the serial clock has returned low, including during the bursts of clock pulses it sends while enable is low. `div_cycle_end` is driven as an isolated one-clock pulse.

// File: rtl/tw_prog_pkg.sv
package tw_prog_pkg;
   // Default field widths of the programming word
   localparam int unsigned DEF_RATIO_W     = 17;
   localparam int unsigned DEF_REF_W       = 4;
   localparam int unsigned DEF_CP_W        = 2;
   localparam int unsigned DEF_TEST_W      = 1;
   localparam int unsigned DEF_PORT_W      = 4;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // When a committed divider ratio reaches the divider
   typedef enum logic {
      RATIO_AT_BOUNDARY = 1'b0,
      RATIO_AT_COMMIT   = 1'b1
   } ratio_mode_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tw_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("tw_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stage_q;
   logic [W-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         prev_q  <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < int'(STAGES); s++) begin
            stage_q[s] <= stage_q[s-1];
         end
         prev_q <= stage_q[STAGES-1];
      end
   end

   assign lvl = stage_q[STAGES-1];

   genvar b;
   generate
      for (b = 0; b < int'(W); b++) begin : g_edge
         assign rise[b] = lvl[b] & ~prev_q[b];
         assign fall[b] = ~lvl[b] & prev_q[b];
      end
   endgenerate
endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
   parameter int unsigned W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] word
);
   generate
      if (W < 2) begin : g_bad_width
         $error("tw_shift: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] word_q;

   // MSB first: new bits enter at bit 0 and older bits move up (R1, R6)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (shift_en) begin
         word_q <= {word_q[W-2:0], din};
      end
   end

   assign word = word_q;
endmodule

// File: rtl/tw_ctrl_regs.sv
module tw_ctrl_regs
   import tw_prog_pkg::*;
#(
   parameter int unsigned RATIO_W    = DEF_RATIO_W,
   parameter int unsigned CTRL_W     = 11,
   parameter ratio_mode_e RATIO_MODE = RATIO_AT_BOUNDARY,
   localparam int unsigned WORD_W    = RATIO_W + CTRL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  logic [WORD_W-1:0]  word_in,
   input  logic               cycle_end,
   output logic [RATIO_W-1:0] ratio,
   output logic [CTRL_W-1:0]  ctrl
);
   generate
      if (RATIO_W < 1 || CTRL_W < 1) begin : g_bad_width
         $error("tw_ctrl_regs: field widths must be positive");
      end
   endgenerate

   logic [CTRL_W-1:0]  ctrl_q;
   logic [RATIO_W-1:0] ratio_q;

   // Control fields follow the commit directly (R3)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (commit) begin
         ctrl_q <= word_in[WORD_W-1:RATIO_W];
      end
   end

   generate
      if (RATIO_MODE == RATIO_AT_BOUNDARY) begin : g_boundary
         logic [RATIO_W-1:0] pend_q;
         logic               pend_vld_q;

         // Pending ratio, applied at the divider cycle boundary (R4, R8)
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q     <= '0;
               pend_vld_q <= 1'b0;
               ratio_q    <= '0;
            end else begin
               if (cycle_end && pend_vld_q) begin
                  ratio_q <= pend_q;
               end
               if (commit) begin
                  pend_q     <= word_in[RATIO_W-1:0];
                  pend_vld_q <= 1'b1;
               end else if (cycle_end) begin
                  pend_vld_q <= 1'b0;
               end
            end
         end
      end else begin : g_commit
         logic unused_cycle_end;
         assign unused_cycle_end = cycle_end;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ratio_q <= '0;
            end else if (commit) begin
               ratio_q <= word_in[RATIO_W-1:0];
            end
         end
      end
   endgenerate

   assign ratio = ratio_q;
   assign ctrl  = ctrl_q;
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
   import tw_prog_pkg::*;
#(
   parameter int unsigned RATIO_W     = DEF_RATIO_W,
   parameter int unsigned REF_W       = DEF_REF_W,
   parameter int unsigned CP_W        = DEF_CP_W,
   parameter int unsigned TEST_W      = DEF_TEST_W,
   parameter int unsigned PORT_W      = DEF_PORT_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
   parameter ratio_mode_e RATIO_MODE  = RATIO_AT_BOUNDARY
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_dat,
   input  logic               ser_en,
   input  logic               div_cycle_end,
   output logic [RATIO_W-1:0] ratio_o,
   output logic [REF_W-1:0]   ref_sel_o,
   output logic [CP_W-1:0]    cp_cur_o,
   output logic [TEST_W-1:0]  test_mode_o,
   output logic [PORT_W-1:0]  port_sink_o
);
   // Field layout of the word, R1: ratio | ref | cp | test | ports (LSB up)
   localparam int unsigned CTRL_W   = REF_W + CP_W + TEST_W + PORT_W;
   localparam int unsigned WORD_W   = RATIO_W + CTRL_W;
   localparam int unsigned REF_LO   = 0;
   localparam int unsigned CP_LO    = REF_LO + REF_W;
   localparam int unsigned TEST_LO  = CP_LO + CP_W;
   localparam int unsigned PORT_LO  = TEST_LO + TEST_W;
   localparam int unsigned IDX_DAT  = 0;
   localparam int unsigned IDX_CLK  = 1;
   localparam int unsigned IDX_EN   = 2;

   generate
      if (WORD_W > 64) begin : g_bad_word
         $error("synth_prog_if: word wider than 64 bits");
      end
      if (REF_W < 1 || CP_W < 1 || TEST_W < 1 || PORT_W < 1) begin : g_bad_field
         $error("synth_prog_if: every field needs at least one bit");
      end
   endgenerate

   logic [2:0]        pin_lvl;
   logic [2:0]        pin_rise;
   logic [2:0]        pin_fall;
   logic              en_lvl;
   logic              shift_stb;
   logic              commit_stb;
   logic [WORD_W-1:0] shift_word;
   logic [CTRL_W-1:0] ctrl_q;
   logic [RATIO_W-1:0] ratio_q;

   tw_sync #(
      .W      (3),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({ser_en, ser_clk, ser_dat}),
      .lvl      (pin_lvl),
      .rise     (pin_rise),
      .fall     (pin_fall)
   );

   // R2: serial clock qualified by the synchronised enable level
   assign en_lvl     = pin_lvl[IDX_EN];
   assign shift_stb  = pin_rise[IDX_CLK] & en_lvl;
   // R3: enable high-to-low commits the word
   assign commit_stb = pin_fall[IDX_EN];

   logic unused_edges;
   assign unused_edges = ^{pin_fall[IDX_CLK], pin_rise[IDX_EN],
                           pin_rise[IDX_DAT], pin_fall[IDX_DAT]};

   tw_shift #(
      .W (WORD_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_stb),
      .din      (pin_lvl[IDX_DAT]),
      .word     (shift_word)
   );

   tw_ctrl_regs #(
      .RATIO_W    (RATIO_W),
      .CTRL_W     (CTRL_W),
      .RATIO_MODE (RATIO_MODE)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit_stb),
      .word_in   (shift_word),
      .cycle_end (div_cycle_end),
      .ratio     (ratio_q),
      .ctrl      (ctrl_q)
   );

   assign ratio_o     = ratio_q;
   assign ref_sel_o   = ctrl_q[REF_LO +: REF_W];
   assign cp_cur_o    = ctrl_q[CP_LO +: CP_W];
   assign test_mode_o = ctrl_q[TEST_LO +: TEST_W];

   // R5: open-drain style port drivers, 1 = sink, 0 = high impedance
   genvar p;
   generate
      for (p = 0; p < int'(PORT_W); p++) begin : g_port
         assign port_sink_o[p] = ctrl_q[PORT_LO + p];
      end
   endgenerate
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
   parameter int unsigned RATIO_W = 17,
   parameter int unsigned CTRL_W  = 11,
   parameter int unsigned PORT_W  = 4,
   localparam int unsigned WORD_W = RATIO_W + CTRL_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en_lvl,
   input logic               commit,
   input logic               cycle_end,
   input logic [WORD_W-1:0]  sreg,
   input logic [RATIO_W-1:0] ratio,
   input logic [CTRL_W-1:0]  ctrl,
   input logic [PORT_W-1:0]  ports
);
   logic seen_commit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_commit_q <= 1'b0;
      else if (commit) seen_commit_q <= 1'b1;
   end

   assert_shift_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_lvl |=> $stable(sreg));

   assert_commit_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (ctrl == $past(sreg[WORD_W-1:RATIO_W])));

   assert_ctrl_only_on_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl != $past(ctrl)) |-> $past(commit));

   assert_ratio_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio != $past(ratio)) |-> $past(cycle_end));

   assert_ports_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_commit_q |-> (ports == '0));
endmodule

bind synth_prog_if synth_prog_if_chk #(
   .RATIO_W (RATIO_W),
   .CTRL_W  (CTRL_W),
   .PORT_W  (PORT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en_lvl    (en_lvl),
   .commit    (commit_stb),
   .cycle_end (div_cycle_end),
   .sreg      (shift_word),
   .ratio     (ratio_o),
   .ctrl      (ctrl_q),
   .ports     (port_sink_o)
);

// File: tb/sim_synth_prog_if.sv
`timescale 1ns/1ps
module sim_synth_prog_if;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_dat = 1'b0;
   logic        ser_en = 1'b0;
   logic        div_cycle_end = 1'b0;
   logic [16:0] ratio_o;
   logic [3:0]  ref_sel_o;
   logic [1:0]  cp_cur_o;
   logic [0:0]  test_mode_o;
   logic [3:0]  port_sink_o;

   int checks = 0;
   int fails  = 0;

   logic [27:0] exp_sreg = '0;
   logic [10:0] exp_ctrl = '0;
   logic [16:0] exp_ratio = '0;
   logic [16:0] exp_pend = '0;
   logic        exp_pvld = 1'b0;

   always #4 clk = ~clk;

   synth_prog_if u0 (
      .clk (clk), .rst_n (rst_n), .ser_clk (ser_clk), .ser_dat (ser_dat),
      .ser_en (ser_en), .div_cycle_end (div_cycle_end), .ratio_o (ratio_o),
      .ref_sel_o (ref_sel_o), .cp_cur_o (cp_cur_o), .test_mode_o (test_mode_o),
      .port_sink_o (port_sink_o)
   );

   // R1 layout: [27:24] ports, [23] test, [22:21] cp, [20:17] ref, [16:0] ratio
   function automatic logic [10:0] ctrl_of(logic [27:0] w);
      return w[27:17];
   endfunction

   function automatic logic [10:0] ctrl_out();
      return {port_sink_o, test_mode_o, cp_cur_o, ref_sel_o};
   endfunction

   task automatic check_ctrl(string req);
      checks++;
      if (ctrl_out() !== exp_ctrl) begin
         fails++;
         $display("FAIL %s control fields: got %h expected %h", req, ctrl_out(), exp_ctrl);
      end
   endtask

   task automatic check_ratio(string req);
      checks++;
      if (ratio_o !== exp_ratio) begin
         fails++;
         $display("FAIL %s ratio: got %h expected %h", req, ratio_o, exp_ratio);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(logic b);
      ser_dat = b;
      wait_cyc(3);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
      wait_cyc(3);
   endtask

   // Shift the low n bits of w, MSB first, with enable high
   task automatic xfer(logic [63:0] w, int n);
      ser_en = 1'b1;
      wait_cyc(4);
      for (int i = n - 1; i >= 0; i--) begin
         send_bit(w[i]);
         exp_sreg = {exp_sreg[26:0], w[i]};
      end
      ser_en = 1'b0;
      wait_cyc(5);
      exp_ctrl = ctrl_of(exp_sreg);
      exp_pend = exp_sreg[16:0];
      exp_pvld = 1'b1;
   endtask

   // Serial clock pulses with enable low: must not shift (R2)
   task automatic junk_clocks(int n);
      for (int i = 0; i < n; i++) begin
         ser_dat = 1'($urandom);
         wait_cyc(3);
         ser_clk = 1'b1;
         wait_cyc(3);
         ser_clk = 1'b0;
         wait_cyc(3);
      end
   endtask

   task automatic cycle_end_pulse();
      div_cycle_end = 1'b1;
      @(negedge clk);
      div_cycle_end = 1'b0;
      wait_cyc(1);
      if (exp_pvld) exp_ratio = exp_pend;
      exp_pvld = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R1..: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h51A7_0C3E));
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      // R5: reset state, ports high impedance
      check_ctrl("R5");
      check_ratio("R5");
      junk_clocks(4);
      check_ctrl("R5 idle");

      // R1: directed full word, fields land in place
      xfer(64'h0A5_2B3C4, 28);
      check_ctrl("R1");
      check_ratio("R4 held before boundary");
      cycle_end_pulse();
      check_ratio("R1");

      // R4: boundary with nothing pending leaves ratio alone
      cycle_end_pulse();
      check_ratio("R4 no pending");

      // R2: clocks with enable low, then a short transfer exposes the word
      junk_clocks(6);
      xfer(64'h0, 0);
      check_ctrl("R2");
      xfer(64'h5, 3);
      check_ctrl("R2 short");
      // R6: fewer bits keeps older contents shifted up
      xfer(64'hC3, 8);
      check_ctrl("R6 short");
      cycle_end_pulse();
      check_ratio("R6 short");
      // R6: longer than 28 bits keeps the last 28
      xfer(64'h3_FEDC_BA98, 34);
      check_ctrl("R6 long");
      cycle_end_pulse();
      check_ratio("R6 long");

      // R7: enable toggles with no clock, word unchanged
      xfer(64'h0, 0);
      check_ctrl("R7");
      cycle_end_pulse();
      check_ratio("R7");

      // R8: two commits before the boundary, latest wins
      xfer(64'hF00_1111, 28);
      check_ratio("R8 held");
      xfer(64'h3FF_E222, 28);
      check_ctrl("R8");
      check_ratio("R8 held");
      cycle_end_pulse();
      check_ratio("R8");

      // Constrained random mix
      for (int k = 0; k < 24; k++) begin
         int n;
         logic [63:0] w;
         w = {$urandom, $urandom};
         n = ($urandom % 4 == 0) ? 20 + int'($urandom % 14) : 28;
         if ($urandom % 3 == 0) junk_clocks(1 + int'($urandom % 3));
         xfer(w, n);
         check_ctrl("R3 random");
         check_ratio("R4 random held");
         if ($urandom % 4 != 0) begin
            cycle_end_pulse();
            check_ratio("R4 random");
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule